// File: doc/BRIEF.md
# Parity-Framed Serial Transmitter

This block turns one character per write into an asynchronous serial frame on a single output line. A frame is a low start bit, then 7, 8 or 9 data bits least significant first, then one parity bit whose sense (odd or even) is programmable, then a high stop bit. Between frames the line rests high. Bit timing comes from an external baud tick, a one-cycle pulse. Each serial bit is held for a fixed, parameterised number of these ticks, 16 by default.

Software or a bus agent raises `tx_en`, drives a character with the write strobe and watches `busy`. While a frame is on the line the block ignores further writes. When the stop bit has been fully sent, the block can raise a one-cycle completion interrupt, gated by a mask input. The character length and parity sense are captured together with the data at the write, so changing them mid-frame does not disturb the character in flight.

Top module: `uart_tx_par`

## Requirements
- R1: A write strobe seen while `tx_en` is low is ignored: `busy` stays low and the line stays high. Dropping `tx_en` during a frame abandons it. In the next cycle the line is high, `busy` is low and no interrupt is raised.
- R2: A write strobe seen with `tx_en` high while idle captures `wr_data` and raises `busy` from the cycle after the write edge. `busy` stays high until the last tick of the stop bit.
- R3: The frame opens with a start bit driven low. Every bit of the frame lasts exactly `TICKS_PER_BIT` baud ticks, and only cycles with `baud_tick` high count toward that total.
- R4: Data bits are sent least significant bit first. The count is set by `len_sel`: 2'b00 gives 7 bits, 2'b01 gives 8, and 2'b10 or 2'b11 give 9. Bits of `wr_data` above the selected length are never sent.
- R5: One parity bit follows the data. It is computed over the selected data bits only. With `par_odd`=1 the ones in data plus parity total an odd number; with `par_odd`=0 they total an even number.
- R6: One stop bit driven high closes the frame, and the line stays high until the next start bit.
- R7: `done_irq` is a single-cycle pulse in the cycle after the stop bit's final tick, raised only if `irq_en` was high; `busy` drops in that same cycle.
- R8: A write during a frame is ignored, as are changes to `len_sel` or `par_odd` during a frame. The bits on the line are those captured at the starting write, and no second frame follows.
- R9: After reset the line is high, `busy` is low and `done_irq` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| tx_en | input | 1 | Transmit enable |
| wr_stb | input | 1 | Write strobe for the holding register |
| wr_data | input | 9 | Character to send (low bits used per length) |
| len_sel | input | 2 | Character length: 00=7, 01=8, 1x=9 bits |
| par_odd | input | 1 | 1 = odd parity, 0 = even parity |
| baud_tick | input | 1 | One-cycle baud tick from an external divider |
| irq_en | input | 1 | Completion interrupt enable |
| tx_line | output | 1 | Serial output, idle high |
| busy | output | 1 | Holding register full / frame in progress |
| done_irq | output | 1 | Completion interrupt pulse |

## Verification
The bench builds the block with `TICKS_PER_BIT` set to 4. This shortens each frame enough that every 9-bit data value can be sent at 9-bit length under both parity senses, and 256 values at each of the 7- and 8-bit lengths. That makes the parity and bit-order checks exhaustive, and it shows that unused upper data bits never leak onto the line. Separate frames cover sparse ticks (one every third cycle), the `len_sel`=2'b11 alias, a write and control changes during a frame, and the two enable cases: a write with `tx_en` low and an abort mid-frame.

// File: rtl/uart_tx_pkg.sv
// Shared types and helpers for the parity-framed serial transmitter.
// Assumes a character never exceeds MAX_BITS data bits.
package uart_tx_pkg;

    localparam int MAX_BITS = 9;
    localparam int BITS_W   = $clog2(MAX_BITS + 1);

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PARITY,
        ST_STOP
    } tx_state_e;

    // Map the length select onto a data-bit count (00=7, 01=8, 1x=9).
    function automatic logic [BITS_W-1:0] len_to_bits(input logic [1:0] sel);
        case (sel)
            2'b00:   return BITS_W'(7);
            2'b01:   return BITS_W'(8);
            default: return BITS_W'(9);
        endcase
    endfunction

endpackage

// File: rtl/uart_tx_bitclk.sv
// Bit-period timer: counts external baud ticks and flags the tick that
// ends the current serial bit. Held at zero while clear is high, so the
// first bit of a frame always starts from a fresh count.
module uart_tx_bitclk #(
    parameter int TICKS_PER_BIT = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic baud_tick,
    output logic bit_end
);
    localparam int CNT_W = (TICKS_PER_BIT > 1) ? $clog2(TICKS_PER_BIT) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(TICKS_PER_BIT - 1);

    logic [CNT_W-1:0] tick_cnt;

    assign bit_end = !clear && baud_tick && (tick_cnt == LAST);

    // Advance the tick count, wrapping at the end of each bit.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            tick_cnt <= '0;
        end else if (baud_tick) begin
            tick_cnt <= (tick_cnt == LAST) ? '0 : tick_cnt + 1'b1;
        end
    end
endmodule

// File: rtl/uart_tx_parity.sv
// Parity generator over the selected number of low data bits.
// Assumes nbits never exceeds MAX_BITS; bits above nbits are masked off.
module uart_tx_parity
    import uart_tx_pkg::*;
(
    input  logic [MAX_BITS-1:0] data,
    input  logic [BITS_W-1:0]   nbits,
    input  logic                odd,
    output logic                par
);
    logic [MAX_BITS-1:0] sel_mask;

    for (genvar g = 0; g < MAX_BITS; g++) begin : g_mask
        assign sel_mask[g] = (nbits > BITS_W'(g));
    end

    // Even parity is the XOR of the kept bits; odd parity inverts it.
    always_comb par = (^(data & sel_mask)) ^ odd;
endmodule

// File: rtl/uart_tx_frame.sv
// Frame sequencer: holds the captured character and walks through
// start, data, parity and stop bits, one step per bit_end. Assumes
// bit_end comes from a timer cleared while this block is idle.
module uart_tx_frame
    import uart_tx_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                tx_en,
    input  logic                wr_stb,
    input  logic [MAX_BITS-1:0] wr_data,
    input  logic [BITS_W-1:0]   nbits,
    input  logic                par_in,
    input  logic                bit_end,
    output logic                idle,
    output logic                frame_done,
    output logic                line
);
    tx_state_e           state;
    logic [MAX_BITS-1:0] shreg;
    logic [BITS_W-1:0]   bits_left;
    logic                par_q;

    assign idle       = (state == ST_IDLE);
    assign frame_done = (state == ST_STOP) && bit_end && tx_en;

    // Drive the line level that belongs to the current frame step.
    always_comb begin
        case (state)
            ST_START:  line = 1'b0;
            ST_DATA:   line = shreg[0];
            ST_PARITY: line = par_q;
            default:   line = 1'b1;
        endcase
    end

    // Step the frame sequence and shift out data bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            shreg     <= '0;
            bits_left <= '0;
            par_q     <= 1'b0;
        end else if (state == ST_IDLE) begin
            if (tx_en && wr_stb) begin
                shreg     <= wr_data;
                bits_left <= nbits;
                par_q     <= par_in;
                state     <= ST_START;
            end
        end else if (!tx_en) begin
            state <= ST_IDLE;
        end else if (bit_end) begin
            case (state)
                ST_START: state <= ST_DATA;
                ST_DATA: begin
                    shreg     <= shreg >> 1;
                    bits_left <= bits_left - 1'b1;
                    if (bits_left == BITS_W'(1)) state <= ST_PARITY;
                end
                ST_PARITY: state <= ST_STOP;
                default:   state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/uart_tx_par.sv
// Parity-framed serial transmitter top. One write starts one frame of
// start, 7/8/9 data bits LSB first, parity, stop. Bit time is
// TICKS_PER_BIT external baud ticks. Assumes baud_tick is one cycle wide.
module uart_tx_par
    import uart_tx_pkg::*;
#(
    parameter int TICKS_PER_BIT = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                tx_en,
    input  logic                wr_stb,
    input  logic [MAX_BITS-1:0] wr_data,
    input  logic [1:0]          len_sel,
    input  logic                par_odd,
    input  logic                baud_tick,
    input  logic                irq_en,
    output logic                tx_line,
    output logic                busy,
    output logic                done_irq
);
    logic [BITS_W-1:0] nbits;
    logic              par_bit;
    logic              idle;
    logic              bit_end;
    logic              frame_done;

    assign nbits = len_to_bits(len_sel);
    assign busy  = !idle;

    uart_tx_parity u_parity (
        .data  (wr_data),
        .nbits (nbits),
        .odd   (par_odd),
        .par   (par_bit)
    );

    uart_tx_bitclk #(.TICKS_PER_BIT(TICKS_PER_BIT)) u_bitclk (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (idle),
        .baud_tick (baud_tick),
        .bit_end   (bit_end)
    );

    uart_tx_frame u_frame (
        .clk        (clk),
        .rst_n      (rst_n),
        .tx_en      (tx_en),
        .wr_stb     (wr_stb),
        .wr_data    (wr_data),
        .nbits      (nbits),
        .par_in     (par_bit),
        .bit_end    (bit_end),
        .idle       (idle),
        .frame_done (frame_done),
        .line       (tx_line)
    );

    // Register the masked completion pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) done_irq <= 1'b0;
        else        done_irq <= frame_done && irq_en;
    end
endmodule

// File: rtl/uart_tx_par_chk.sv
// Protocol checker for the transmitter, attached to every instance by bind.
module uart_tx_par_chk (
    input logic clk,
    input logic rst_n,
    input logic tx_en,
    input logic wr_stb,
    input logic irq_en,
    input logic tx_line,
    input logic busy,
    input logic done_irq
);
    AST_OFF_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !tx_en) |=> !busy); // R1
    AST_ABORT_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !tx_en) |=> (!busy && !done_irq)); // R1
    AST_WRITE_SETS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && tx_en && wr_stb) |=> busy); // R2
    AST_START_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> !tx_line); // R3
    AST_IDLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> tx_line); // R6
    AST_STOP_BEFORE_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        done_irq |-> $past(tx_line)); // R6
    AST_IRQ_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        done_irq |-> $fell(busy)); // R7
    AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        done_irq |-> $past(irq_en)); // R7
    AST_IRQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        done_irq |=> !done_irq); // R7
endmodule

bind uart_tx_par uart_tx_par_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .tx_en    (tx_en),
    .wr_stb   (wr_stb),
    .irq_en   (irq_en),
    .tx_line  (tx_line),
    .busy     (busy),
    .done_irq (done_irq)
);

// File: tb/tb_uart_tx_par.sv
`timescale 1ns/1ps
module tb_uart_tx_par;
    localparam int TPB = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tx_en = 1'b0;
    logic       wr_stb = 1'b0;
    logic [8:0] wr_data = '0;
    logic [1:0] len_sel = 2'b00;
    logic       par_odd = 1'b0;
    logic       baud_tick = 1'b0;
    logic       irq_en = 1'b0;
    logic       tx_line;
    logic       busy;
    logic       done_irq;

    int checks = 0;
    int failures = 0;
    int cycles = 0;

    always #2.5 clk = ~clk;

    uart_tx_par #(.TICKS_PER_BIT(TPB)) dut (
        .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .wr_stb(wr_stb),
        .wr_data(wr_data), .len_sel(len_sel), .par_odd(par_odd),
        .baud_tick(baud_tick), .irq_en(irq_en), .tx_line(tx_line),
        .busy(busy), .done_irq(done_irq)
    );

    always @(posedge clk) begin
        cycles++;
        if (cycles == 190000) begin
            failures++;
            $display("FAIL watchdog: run did not end, actual=%0d expected<%0d cycles", cycles, 190000);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int nb_of(input logic [1:0] s);
        return (s == 2'b00) ? 7 : (s == 2'b01) ? 8 : 9;
    endfunction

    // Send one frame and compare the line bit by bit against the expected frame.
    task automatic send_frame(input logic [8:0] d, input logic [1:0] ls, input logic odd,
                              input logic ien, input int period, input bit midwrite);
        int n;
        int total;
        int ticks;
        int cyc;
        int bad;
        int busybad;
        logic par;
        logic [11:0] expv;
        n = nb_of(ls);
        total = n + 3;
        ticks = 0; cyc = 0; bad = 0; busybad = 0;
        par = odd;
        for (int i = 0; i < n; i++) par = par ^ d[i];
        expv = '1;
        expv[0] = 1'b0;
        for (int i = 0; i < n; i++) expv[1 + i] = d[i];
        expv[n + 1] = par;
        expv[n + 2] = 1'b1;
        @(negedge clk);
        tx_en = 1'b1; wr_data = d; len_sel = ls; par_odd = odd; irq_en = ien;
        wr_stb = 1'b1; baud_tick = 1'b0;
        @(posedge clk);
        while (ticks < total * TPB) begin
            @(negedge clk);
            wr_stb = midwrite && (cyc == 5);
            if (midwrite && cyc == 5) begin
                wr_data = ~d; len_sel = ~ls; par_odd = ~odd;
            end
            if (tx_line !== expv[ticks / TPB]) bad++;
            if (busy !== 1'b1) busybad++;
            baud_tick = (cyc % period) == 0;
            @(posedge clk);
            if (baud_tick) ticks++;
            cyc++;
        end
        @(negedge clk);
        baud_tick = 1'b0; wr_stb = 1'b0;
        if (midwrite) chk(bad == 0, "R8 frame altered by mid-frame write", bad, 0);
        else          chk(bad == 0, "R3/R4/R5/R6 frame bit mismatches", bad, 0);
        chk(busybad == 0, "R2 busy low during frame", busybad, 0);
        chk(busy == 1'b0, "R7 busy after stop", int'(busy), 0);
        chk(done_irq == ien, "R7 completion pulse", int'(done_irq), int'(ien));
        chk(tx_line == 1'b1, "R6 idle level after stop", int'(tx_line), 1);
        @(negedge clk);
        chk(done_irq == 1'b0, "R7 pulse width", int'(done_irq), 0);
    endtask

    initial begin
        // R9: reset state
        repeat (3) @(negedge clk);
        chk(tx_line == 1'b1, "R9 line in reset", int'(tx_line), 1);
        chk(busy == 1'b0, "R9 busy in reset", int'(busy), 0);
        chk(done_irq == 1'b0, "R9 irq in reset", int'(done_irq), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(tx_line == 1'b1 && busy == 1'b0, "R9 state after reset", int'({tx_line, busy}), 2);

        // R1: write with transmit disabled
        tx_en = 1'b0; wr_data = 9'h000; wr_stb = 1'b1; baud_tick = 1'b1;
        @(negedge clk);
        wr_stb = 1'b0;
        chk(busy == 1'b0, "R1 busy after disabled write", int'(busy), 0);
        repeat (3) @(negedge clk);
        chk(tx_line == 1'b1, "R1 line after disabled write", int'(tx_line), 1);
        baud_tick = 1'b0;

        // Exhaustive-ish sweeps over lengths, parity and data (R3 R4 R5 R6 R7)
        for (int odd = 0; odd < 2; odd++) begin
            for (int d = 0; d < 256; d++)
                send_frame(9'(d), 2'b00, odd[0], 9'(d) >> 1 & 9'h1 ? 1'b1 : 1'b0, 1, 1'b0);
            for (int d = 0; d < 256; d++)
                send_frame(9'(d) ^ 9'h100, 2'b01, odd[0], d[2], 1, 1'b0);
            for (int d = 0; d < 512; d++)
                send_frame(9'(d), 2'b10, odd[0], d[1], 1, 1'b0);
        end

        // R4: 2'b11 aliases to 9 bits
        send_frame(9'h1A5, 2'b11, 1'b1, 1'b1, 1, 1'b0);
        // R3: sparse ticks, bit time counted in ticks
        send_frame(9'h0C3, 2'b01, 1'b0, 1'b1, 3, 1'b0);
        // R8: write and control changes during a frame
        send_frame(9'h05A, 2'b01, 1'b1, 1'b1, 1, 1'b1);
        repeat (4) @(negedge clk);
        chk(busy == 1'b0, "R8 no frame from ignored write", int'(busy), 0);

        // R1: abort by dropping tx_en mid-frame
        tx_en = 1'b1; irq_en = 1'b1; wr_data = 9'h0FF; len_sel = 2'b01; wr_stb = 1'b1;
        baud_tick = 1'b1;
        @(negedge clk);
        wr_stb = 1'b0;
        repeat (6) @(negedge clk);
        chk(busy == 1'b1, "R1 busy before abort", int'(busy), 1);
        tx_en = 1'b0;
        @(negedge clk);
        chk(busy == 1'b0, "R1 busy after abort", int'(busy), 0);
        chk(tx_line == 1'b1, "R1 line after abort", int'(tx_line), 1);
        chk(done_irq == 1'b0, "R1 no irq on abort", int'(done_irq), 0);
        repeat (40) @(negedge clk);
        chk(done_irq == 1'b0 && tx_line == 1'b1, "R1 quiet after abort", int'({done_irq, tx_line}), 1);
        baud_tick = 1'b0;

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule